// File: doc/BRIEF.md
# Programmable Interval Timer with Output Routing

This block is a 16-bit down-counting interval timer with a byte-wide register port. A host loads the period one byte at a time into a low and a high period register. It then sends one-byte commands to a control address. These commands start and stop the count, choose the clock source, choose the mode, gate the interrupt, and connect the time-out output to a general-purpose pin.

The count advances on every system clock cycle or on each rising edge of an external timer clock. The external clock is first brought into the system clock domain by a synchronizer. In one-shot mode the timer produces one single-cycle pulse and then stops. In periodic mode it reloads at each time-out and toggles its output, so the output is a square wave. The time-out rate is the selected clock rate divided by the period. A period of zero keeps the timer idle.

Each time-out sets a sticky status flag. When the interrupt is enabled, that flag drives the interrupt line. Reading the status address clears the flag.

Top module: `tmr16_unit`

## Requirements
- R1: After reset, both period bytes, the control readback and the status read as 0, and `irq`, `tmr_out` and `pin_out` are 0. The reset configuration is interrupt disabled, oscillator clock, one-shot mode, and pin not routed.
- R2: Address 0 holds period bits 7:0 and address 1 holds period bits 15:8. A read of either address returns the value that was written, even while the counter is running. Read data equals the addressed value while `bus_rd` is high and is 0 otherwise.
- R3: A write to address 2 is a command: 0x01 interrupt on, 0x02 interrupt off, 0x03 oscillator clock, 0x04 external clock, 0x05 start, 0x06 stop, 0x07 one-shot, 0x08 periodic, 0x09 route to pin, 0x0A unroute, 0x0C clear. Any other byte changes nothing. A read of address 2 returns bit0 interrupt enable, bit1 external clock, bit2 periodic, bit3 routed and bit4 running.
- R4: With the oscillator clock and period N, the first time-out comes N cycles after the start write edge. Later time-outs follow every N cycles.
- R5: With the external clock selected, each rising edge of `ext_clk` is counted once after a two-flop synchronizer. When `ext_clk` is held at a steady level, the count does not advance.
- R6: In one-shot mode a time-out drives `tmr_out` high for exactly one cycle and clears the running bit.
- R7: In periodic mode `tmr_out` toggles at every time-out, and the counter reloads the period.
- R8: A start with period 0 leaves the timer stopped. A running timer whose period is set to 0 stops, and no time-out follows.
- R9: The clear command stops the counter, drives `tmr_out` low and clears the status. It leaves the period bytes and the configuration unchanged.
- R10: Status (address 3, bit0) sets on a time-out and holds until a read of address 3 or a clear command. A time-out in the same cycle as a status read wins. `irq` is status AND interrupt enable.
- R11: While routed, `pin_out` follows `tmr_out`. While not routed, `pin_out` is 0.
- R12: A stop holds the count, and no time-out occurs while stopped. A start always reloads the full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of status clears it) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data or command byte |
| bus_rdata | output | 8 | Read data |
| ext_clk | input | 1 | External timer clock, slower than half of `clk` |
| irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Time-out output |
| pin_out | output | 1 | Routed copy of the time-out output |

## Verification
Some properties are checked on every cycle by the assertions:
- status stays set until it is read or cleared;
- a one-shot time-out stops the counter;
- a periodic time-out flips the output;
- a zero period halts a running count;
- a stopped count holds;
- a clear keeps the period;
- an unknown command leaves the configuration alone;
- a synchronized external edge produces only a single tick.

Other behaviour can only be shown by the bench scenarios:
- the exact spacing of time-outs for a given period and clock source;
- the value returned by reads;
- the pulse width;
- reload on restart;
- pin routing.

The bench shows these through a cycle model compared on every clock.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   typedef enum logic [1:0] {
      RA_PER_LO = 2'd0,
      RA_PER_HI = 2'd1,
      RA_CTRL   = 2'd2,
      RA_STAT   = 2'd3
   } reg_addr_e;

   typedef enum logic [7:0] {
      CMD_IRQ_ON   = 8'h01,
      CMD_IRQ_OFF  = 8'h02,
      CMD_SRC_OSC  = 8'h03,
      CMD_SRC_EXT  = 8'h04,
      CMD_START    = 8'h05,
      CMD_STOP     = 8'h06,
      CMD_ONESHOT  = 8'h07,
      CMD_PERIODIC = 8'h08,
      CMD_PIN_ON   = 8'h09,
      CMD_PIN_OFF  = 8'h0A,
      CMD_CLEAR    = 8'h0C
   } cmd_e;

   // Bit order matches the control readback: route, periodic, ext, irq_en.
   typedef struct packed {
      logic pin_route;
      logic periodic;
      logic ext_src;
      logic irq_en;
   } cfg_t;

endpackage

// File: rtl/tmr16_tick.sv
module tmr16_tick #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_EXT     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic ext_sel,
   output logic tick
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr16_tick: SYNC_STAGES must be at least 2");
   end

   if (HAS_EXT) begin : g_ext
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   last_q;
      logic                   rise;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
         end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            last_q <= sync_q[SYNC_STAGES-1];
         end
      end

      assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
      assign tick = ext_sel ? rise : 1'b1;

      // R5: one external edge yields one tick, never two in a row
      a_r5_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_sel && tick) |=> (!ext_sel || !tick));
   end else begin : g_osc_only
      assign tick = 1'b1;
   end

endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
   import tmr16_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned PER_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              fire,
   input  logic              running,
   output logic [BYTE_W-1:0] rdata,
   output logic [PER_W-1:0]  period,
   output cfg_t              cfg,
   output logic              start_p,
   output logic              stop_p,
   output logic              clr_p,
   output logic              irq
);

   localparam int unsigned NBYTES = PER_W / BYTE_W;

   if (PER_W != 2 * BYTE_W) begin : g_bad_width
      $error("tmr16_regs: PER_W must be two bytes wide");
   end
   if (BYTE_W < 8) begin : g_bad_byte
      $error("tmr16_regs: BYTE_W must hold a command byte");
   end

   logic cmd_wr;
   logic stat_rd;
   logic status_q;
   cfg_t cfg_q;

   assign cmd_wr  = wr_en && (addr == RA_CTRL);
   assign stat_rd = rd_en && (addr == RA_STAT);
   assign start_p = cmd_wr && (wdata == BYTE_W'(CMD_START));
   assign stop_p  = cmd_wr && (wdata == BYTE_W'(CMD_STOP));
   assign clr_p   = cmd_wr && (wdata == BYTE_W'(CMD_CLEAR));

   // period bytes: byte b sits at address b
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (addr == 2'(b)))
            q <= wdata;
      end
      assign period[b*BYTE_W +: BYTE_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cmd_wr) begin
         case (wdata)
            BYTE_W'(CMD_IRQ_ON):   cfg_q.irq_en    <= 1'b1;
            BYTE_W'(CMD_IRQ_OFF):  cfg_q.irq_en    <= 1'b0;
            BYTE_W'(CMD_SRC_OSC):  cfg_q.ext_src   <= 1'b0;
            BYTE_W'(CMD_SRC_EXT):  cfg_q.ext_src   <= 1'b1;
            BYTE_W'(CMD_ONESHOT):  cfg_q.periodic  <= 1'b0;
            BYTE_W'(CMD_PERIODIC): cfg_q.periodic  <= 1'b1;
            BYTE_W'(CMD_PIN_ON):   cfg_q.pin_route <= 1'b1;
            BYTE_W'(CMD_PIN_OFF):  cfg_q.pin_route <= 1'b0;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= 1'b0;
      else if (clr_p)
         status_q <= 1'b0;
      else if (fire)
         status_q <= 1'b1;
      else if (stat_rd)
         status_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            RA_PER_LO: rdata = period[BYTE_W-1:0];
            RA_PER_HI: rdata = period[PER_W-1:BYTE_W];
            RA_CTRL:   rdata = BYTE_W'({running, cfg_q});
            default:   rdata = BYTE_W'(status_q);
         endcase
      end
   end

   assign cfg = cfg_q;
   assign irq = cfg_q.irq_en & status_q;

   // R10: status is sticky until read or cleared
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_p && !stat_rd) |=> status_q);

   // R9: clear command never disturbs the period bytes
   a_r9_period_kept: assert property (@(posedge clk) disable iff (!rst_n)
      clr_p |=> $stable(period));

   // R3: writes of undefined command bytes leave the configuration alone
   a_r3_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !(wdata inside {BYTE_W'(CMD_IRQ_ON), BYTE_W'(CMD_IRQ_OFF),
         BYTE_W'(CMD_SRC_OSC), BYTE_W'(CMD_SRC_EXT), BYTE_W'(CMD_ONESHOT),
         BYTE_W'(CMD_PERIODIC), BYTE_W'(CMD_PIN_ON), BYTE_W'(CMD_PIN_OFF)}))
      |=> $stable(cfg_q));

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
   parameter int unsigned PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [PER_W-1:0] period,
   input  logic             periodic,
   input  logic             start_p,
   input  logic             stop_p,
   input  logic             clr_p,
   output logic             fire,
   output logic             running,
   output logic             tmr_out
);

   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   if (PER_W < 2) begin : g_bad_per
      $error("tmr16_count: PER_W too small");
   end

   logic [PER_W-1:0] cnt_q;
   logic             run_q;
   logic             tgl_q;
   logic             pulse_q;
   logic             per_zero;

   assign per_zero = (period == '0);
   assign fire     = run_q & tick & ~per_zero & (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         tgl_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else if (clr_p) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         tgl_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fire;
         if (start_p) begin
            if (!per_zero) begin
               run_q <= 1'b1;
               cnt_q <= period;
            end
         end else if (stop_p) begin
            run_q <= 1'b0;
         end else if (run_q) begin
            if (per_zero) begin
               run_q <= 1'b0;
            end else if (tick) begin
               if (cnt_q == ONE) begin
                  if (periodic) begin
                     cnt_q <= period;
                     tgl_q <= ~tgl_q;
                  end else begin
                     run_q <= 1'b0;
                     cnt_q <= '0;
                  end
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
         end
      end
   end

   assign tmr_out = periodic ? tgl_q : pulse_q;
   assign running = run_q;

   // R6: a one-shot time-out leaves the timer stopped
   a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !periodic && !start_p) |=> !run_q);

   // R7: a periodic time-out flips the square wave
   a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && periodic && !clr_p && !start_p && !stop_p) |=> (tgl_q != $past(tgl_q)));

   // R8: a zero period halts a running counter
   a_r8_zero_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && per_zero && !start_p) |=> !run_q);

   // R12: a stopped counter holds its value
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !start_p && !clr_p) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
   import tmr16_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned PER_W       = 2 * BYTE_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_EXT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              ext_clk,
   output logic              irq,
   output logic              tmr_out,
   output logic              pin_out
);

   logic [PER_W-1:0] period;
   cfg_t             cfg;
   logic             start_p, stop_p, clr_p;
   logic             fire, running, tick, out_raw;

   tmr16_regs #(.BYTE_W(BYTE_W), .PER_W(PER_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .rd_en   (bus_rd),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .fire    (fire),
      .running (running),
      .rdata   (bus_rdata),
      .period  (period),
      .cfg     (cfg),
      .start_p (start_p),
      .stop_p  (stop_p),
      .clr_p   (clr_p),
      .irq     (irq)
   );

   tmr16_tick #(.SYNC_STAGES(SYNC_STAGES), .HAS_EXT(HAS_EXT)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_clk (ext_clk),
      .ext_sel (cfg.ext_src),
      .tick    (tick)
   );

   tmr16_count #(.PER_W(PER_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .period   (period),
      .periodic (cfg.periodic),
      .start_p  (start_p),
      .stop_p   (stop_p),
      .clr_p    (clr_p),
      .fire     (fire),
      .running  (running),
      .tmr_out  (out_raw)
   );

   assign tmr_out = out_raw;
   assign pin_out = cfg.pin_route & out_raw;

endmodule

// File: tb/tmr16_unit_test.sv
module tmr16_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int QT         = CLK_PERIOD / 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ext_clk = 1'b0;
   logic       irq, tmr_out, pin_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit ext_run = 1'b0;

   tmr16_unit uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_clk(ext_clk), .irq(irq), .tmr_out(tmr_out), .pin_out(pin_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- behavioural reference model ----------------
   int m_per, m_cnt;
   bit m_run, m_tgl, m_pulse, m_stat;
   bit m_ie, m_ext, m_periodic, m_route;
   bit m_sq[$];

   always @(posedge clk or negedge rst_n) begin
      bit tk, isc, fire;
      int code;
      if (!rst_n) begin
         m_per = 0; m_cnt = 0; m_run = 0; m_tgl = 0; m_pulse = 0; m_stat = 0;
         m_ie = 0; m_ext = 0; m_periodic = 0; m_route = 0;
         m_sq = '{0, 0, 0};
      end else begin
         tk = !m_ext || (m_sq[1] && !m_sq[2]);
         m_sq.push_front(ext_clk);
         void'(m_sq.pop_back());
         isc  = bus_wr && bus_addr == 2;
         code = bus_wdata;
         fire = m_run && tk && m_per != 0 && m_cnt == 1;
         if (isc && code == 12) m_stat = 0;
         else if (fire) m_stat = 1;
         else if (bus_rd && bus_addr == 3) m_stat = 0;
         if (isc && code == 12) begin
            m_run = 0; m_cnt = 0; m_tgl = 0; m_pulse = 0;
         end else begin
            m_pulse = fire;
            if (isc && code == 5) begin
               if (m_per != 0) begin m_run = 1; m_cnt = m_per; end
            end else if (isc && code == 6) begin
               m_run = 0;
            end else if (m_run) begin
               if (m_per == 0) m_run = 0;
               else if (tk) begin
                  if (m_cnt == 1) begin
                     if (m_periodic) begin m_cnt = m_per; m_tgl = !m_tgl; end
                     else begin m_run = 0; m_cnt = 0; end
                  end else m_cnt = m_cnt - 1;
               end
            end
         end
         if (bus_wr && bus_addr == 0) m_per = (m_per & 'hFF00) | bus_wdata;
         if (bus_wr && bus_addr == 1) m_per = (m_per & 'h00FF) | (int'(bus_wdata) << 8);
         if (isc) begin
            case (code)
               1: m_ie = 1;       2: m_ie = 0;
               3: m_ext = 0;      4: m_ext = 1;
               7: m_periodic = 0; 8: m_periodic = 1;
               9: m_route = 1;    10: m_route = 0;
               default: ;
            endcase
         end
      end
   end

   function automatic int model_out();
      return m_periodic ? m_tgl : m_pulse;
   endfunction

   function automatic int model_rdata();
      if (!bus_rd) return 0;
      case (bus_addr)
         0: return m_per & 'hFF;
         1: return (m_per >> 8) & 'hFF;
         2: return (m_run << 4) | (m_route << 3) | (m_periodic << 2) | (m_ext << 1) | m_ie;
         default: return m_stat;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // per-cycle comparison against the model, away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #(QT);
         if (rst_n && !done) begin
            chk("R7",  int'(tmr_out),   model_out(),              "tmr_out vs model");
            chk("R11", int'(pin_out),   m_route & model_out(),    "pin_out vs model");
            chk("R10", int'(irq),       m_ie & m_stat,            "irq vs model");
            chk("R2",  int'(bus_rdata), model_rdata(),            "rdata vs model");
         end
      end
   end

   // external clock generator: toggles every 4 cycles on falling edges
   initial begin
      int n = 0;
      forever begin
         @(negedge clk);
         if (ext_run) begin
            n++;
            if (n == 4) begin ext_clk = ~ext_clk; n = 0; end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R4 watchdog actual=hung expected=finished");
         done = 1'b1;
         summary();
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 2'(a);
      #(QT);
      chk(tag, int'(bus_rdata), exp, $sformatf("read addr %0d", a));
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // number of edges until tmr_out changes
   task automatic gap(output int n);
      logic v;
      #(QT);
      v = tmr_out;
      n = 0;
      do begin
         @(negedge clk);
         #(QT);
         n++;
      end while (tmr_out == v && n < 300);
   endtask

   task automatic count_high(input int cyc, output int n);
      n = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         #(QT);
         if (tmr_out) n++;
      end
   endtask

   initial begin
      int g, h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(0, 0, "R1");
      rd_chk(1, 0, "R1");
      rd_chk(2, 0, "R1");
      rd_chk(3, 0, "R1");
      chk("R1", int'(irq), 0, "irq after reset");
      chk("R1", int'(tmr_out), 0, "tmr_out after reset");
      chk("R1", int'(pin_out), 0, "pin_out after reset");

      // R3 command decode, undefined codes ignored
      wr(2, 8'h01);
      rd_chk(2, 8'h01, "R3");
      wr(2, 8'h0B);
      wr(2, 8'h15);
      rd_chk(2, 8'h01, "R3");

      // R2 readback of programmed period, not the live count
      wr(0, 8'h34);
      wr(1, 8'h12);
      rd_chk(0, 8'h34, "R2");
      rd_chk(1, 8'h12, "R2");
      wr(2, 8'h05);
      repeat (5) @(negedge clk);
      rd_chk(0, 8'h34, "R2");
      rd_chk(2, 8'h11, "R3");
      wr(2, 8'h06);
      rd_chk(2, 8'h01, "R3");

      // R4 and R7: oscillator clock, periodic, period 5
      wr(0, 5);
      wr(1, 0);
      wr(2, 8'h08);
      wr(2, 8'h05);
      gap(g); chk("R4", g, 5, "first time-out distance");
      gap(g); chk("R4", g, 5, "second time-out distance");
      gap(g); chk("R7", g, 5, "square wave half period");
      chk("R10", int'(irq), 1, "irq after time-out");

      // R11 routing
      wr(2, 8'h09);
      h = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); #(QT);
         if (pin_out !== tmr_out) h++;
      end
      chk("R11", h, 0, "routed pin mismatches");
      wr(2, 8'h0A);
      h = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); #(QT);
         if (pin_out) h++;
      end
      chk("R11", h, 0, "unrouted pin high cycles");

      // R10 sticky status and read-clear
      wr(2, 8'h06);
      rd_chk(3, 1, "R10");
      rd_chk(3, 0, "R10");
      chk("R10", int'(irq), 0, "irq after status read");

      // R12 stop holds, start reloads; R6 one-shot pulse
      wr(2, 8'h07);
      wr(0, 6);
      wr(2, 8'h05);
      repeat (2) @(negedge clk);
      wr(2, 8'h06);
      count_high(12, h);
      chk("R12", h, 0, "no time-out while stopped");
      wr(2, 8'h05);
      gap(g); chk("R12", g, 6, "restart reloads full period");
      @(negedge clk); #(QT);
      chk("R6", int'(tmr_out), 0, "one-shot pulse width");
      count_high(15, h);
      chk("R6", h, 0, "no second one-shot pulse");
      rd_chk(2, 8'h01, "R6");

      // R8 zero period
      wr(0, 0);
      wr(2, 8'h05);
      rd_chk(2, 8'h01, "R8");
      count_high(10, h);
      chk("R8", h, 0, "zero period idle");

      // R9 clear command
      wr(0, 4);
      wr(2, 8'h08);
      wr(2, 8'h05);
      gap(g); chk("R4", g, 4, "period 4 distance");
      repeat (2) @(negedge clk);
      wr(2, 8'h0C);
      #(QT);
      chk("R9", int'(tmr_out), 0, "output after clear");
      rd_chk(0, 4, "R9");
      rd_chk(3, 0, "R9");
      rd_chk(2, 8'h05, "R9");

      // R5 external clock, period 3, ext toggling every 4 cycles
      wr(0, 3);
      ext_run = 1'b1;
      wr(2, 8'h04);
      wr(2, 8'h05);
      gap(g);
      gap(g); chk("R5", g, 24, "external time-out distance");
      gap(g); chk("R5", g, 24, "external time-out distance repeat");
      ext_run = 1'b0;
      repeat (4) @(negedge clk);
      h = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); #(QT);
         if (tmr_out != uut.tmr_out) h++;
      end
      gap(g); chk("R5", g, 300, "no count with steady ext_clk");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule